// File: doc/BRIEF.md
# PLL Control Register Block with Lock-Change Interrupt

This block is the software-facing control register set for a clock-generation phase-locked loop. It holds the loop enable, the base-clock source select, the loop multiplier, a 4-bit oscillator range value, an automatic-bandwidth mode bit and an interrupt enable. It exposes these settings to the analog loop and the clock mux as registered outputs. It also enforces the consistency rules that keep the loop from being reprogrammed while it runs. The rules also keep the loop from being started, or chosen as the clock source, when the range value is zero.

The block watches the loop's lock indicator through a synchronizer. In automatic-bandwidth mode, every change of lock, whether the loop enters or leaves lock, sets a sticky flag. The flag raises an interrupt request when it is enabled. Software reads the control register to learn that a change happened. It reads the synchronized lock level in the bandwidth register to learn which way the change went. Reading the control register clears the flag.

Top module: `pllc_ctrl`

## Requirements
- R1: After reset, the loop enable, the clock select, the interrupt enable, the automatic mode bit and the flag are 0. The range field is 6 and the multiplier field is 1.
- R2: Register map. Address 0 is the control register: bit 7 is the interrupt enable, bit 6 is the flag (read-only), bit 5 is the loop enable and bit 4 is the clock select. Address 1 is the bandwidth register: bit 7 is the automatic mode bit and bit 6 is the synchronized lock level (read-only). Address 2 is the configuration register: bits 7:4 hold the range and bits 3:0 hold the multiplier. Unused bits and address 3 read 0.
- R3: While the loop enable is 1, writes to the configuration register leave the range and the multiplier unchanged.
- R4: While the range is 0, the loop enable and the clock select are 0. A write that tries to set either of them is refused.
- R5: In automatic mode, each rising or falling change of the lock input sets the flag exactly once. The flag becomes set on the third rising clock edge after the change.
- R6: The flag is set by a lock change whether or not the interrupt enable is 1.
- R7: With the automatic mode bit at 0, the flag reads 0, lock changes do not set it, and the interrupt output stays 0.
- R8: The interrupt output is 1 exactly when both the flag and the interrupt enable are 1.
- R9: A read of the control register clears the flag on the following edge. If a lock change reaches the flag on that same edge, the flag stays set.
- R10: The lock level bit in the bandwidth register follows the lock input after two clock edges.
- R11: A bus write to the flag bit has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| lock_in | input | 1 | Asynchronous lock indicator from the loop |
| pll_en | output | 1 | Loop enable |
| clk_sel | output | 1 | Selects the loop output as base clock |
| mult_sel | output | MULT_W | Loop multiplier value |
| range_sel | output | 4 | Oscillator range value |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every range and multiplier value with the loop stopped, then repeats the sweep with the loop running. A design whose write protection leaked would show the new values in the second pass. It tries to start the loop and to pick the loop clock while the range is zero; a design missing the veto would drive a dead loop or a broken clock. It times a lock change edge by edge in both directions. A missing or extra synchronizer stage moves the flag by a cycle, and a level detector instead of a change detector would miss one direction. It also lands a lock change on the very edge of a clearing read: a design that let the read win would silently lose an interrupt.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_BW   = 2'd1,
      ADR_CFG  = 2'd2,
      ADR_NONE = 2'd3
   } pllc_addr_e;

   localparam int CTRL_IE_BIT   = 7;
   localparam int CTRL_FLAG_BIT = 6;
   localparam int CTRL_ON_BIT   = 5;
   localparam int CTRL_CS_BIT   = 4;
   localparam int BW_AUTO_BIT   = 7;
   localparam int BW_LOCK_BIT   = 6;
   localparam int RANGE_W       = 4;
   localparam int DATA_W        = 8;
endpackage

// File: rtl/pllc_lock_sync.sv
module pllc_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   output logic lock_lvl,
   output logic lock_chg
);
   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("pllc_lock_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], lock_in};
   end

   assign lock_lvl = chain_q[LAST-1];
   assign lock_chg = chain_q[LAST] ^ chain_q[LAST-1];
endmodule

// File: rtl/pllc_irq_flag.sv
module pllc_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_on,
   input  logic lock_chg,
   input  logic rd_clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (!auto_on) flag_q <= 1'b0;
      else if (lock_chg) flag_q <= 1'b1;
      else if (rd_clr)   flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & irq_en;

   // R5, R6: a change in automatic mode always lands in the flag
   a_r5_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_on && lock_chg) |=> flag_q);
   // R7: manual mode empties the flag
   a_r7_manual_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_on |=> !flag_q);
   // R9: a read with no competing change clears the flag
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !lock_chg) |=> !flag_q);
endmodule

// File: rtl/pllc_ctrl.sv
module pllc_ctrl
   import pllc_pkg::*;
#(
   parameter int              MULT_W      = 4,
   parameter int              SYNC_STAGES = 2,
   parameter logic [3:0]      RANGE_RST   = 4'd6,
   parameter logic [MULT_W-1:0] MULT_RST  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              lock_in,
   output logic              pll_en,
   output logic              clk_sel,
   output logic [MULT_W-1:0] mult_sel,
   output logic [3:0]        range_sel,
   output logic              irq
);
   localparam int MULT_MAX = DATA_W - RANGE_W;

   if (MULT_W < 1 || MULT_W > MULT_MAX) begin : g_bad_mult
      $error("pllc_ctrl: MULT_W out of range");
   end
   if (RANGE_RST == 4'd0) begin : g_bad_range
      $error("pllc_ctrl: reset range must be nonzero");
   end

   logic              on_q, cs_q, ie_q, auto_q;
   logic [3:0]        range_q;
   logic [MULT_W-1:0] mult_q;
   logic              on_nx, cs_nx;
   logic [3:0]        range_nx;
   logic [MULT_W-1:0] mult_nx;
   logic              wr_ctrl, wr_bw, wr_cfg, rd_ctrl;
   logic              lock_lvl, lock_chg, flag;

   assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == ADR_CTRL);
   assign wr_bw   = bus_sel &  bus_wr & (bus_addr == ADR_BW);
   assign wr_cfg  = bus_sel &  bus_wr & (bus_addr == ADR_CFG);
   assign rd_ctrl = bus_sel & ~bus_wr & (bus_addr == ADR_CTRL);

   always_comb begin
      range_nx = range_q;
      mult_nx  = mult_q;
      if (wr_cfg && !on_q) begin
         range_nx = bus_wdata[DATA_W-1 -: RANGE_W];
         mult_nx  = bus_wdata[MULT_W-1:0];
      end
      on_nx = wr_ctrl ? bus_wdata[CTRL_ON_BIT] : on_q;
      cs_nx = wr_ctrl ? bus_wdata[CTRL_CS_BIT] : cs_q;
      if (range_nx == 4'd0) begin
         on_nx = 1'b0;
         cs_nx = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q    <= 1'b0;
         cs_q    <= 1'b0;
         ie_q    <= 1'b0;
         auto_q  <= 1'b0;
         range_q <= RANGE_RST;
         mult_q  <= MULT_RST;
      end else begin
         on_q    <= on_nx;
         cs_q    <= cs_nx;
         range_q <= range_nx;
         mult_q  <= mult_nx;
         if (wr_ctrl) ie_q   <= bus_wdata[CTRL_IE_BIT];
         if (wr_bw)   auto_q <= bus_wdata[BW_AUTO_BIT];
      end
   end

   pllc_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_in  (lock_in),
      .lock_lvl (lock_lvl),
      .lock_chg (lock_chg)
   );

   pllc_irq_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .auto_on  (auto_q),
      .lock_chg (lock_chg),
      .rd_clr   (rd_ctrl),
      .irq_en   (ie_q),
      .flag     (flag),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADR_CTRL: begin
            bus_rdata[CTRL_IE_BIT]   = ie_q;
            bus_rdata[CTRL_FLAG_BIT] = flag;
            bus_rdata[CTRL_ON_BIT]   = on_q;
            bus_rdata[CTRL_CS_BIT]   = cs_q;
         end
         ADR_BW: begin
            bus_rdata[BW_AUTO_BIT] = auto_q;
            bus_rdata[BW_LOCK_BIT] = lock_lvl;
         end
         ADR_CFG:  bus_rdata = {range_q, 4'b0} | DATA_W'(mult_q);
         default:  bus_rdata = '0;
      endcase
   end

   assign pll_en    = on_q;
   assign clk_sel   = cs_q;
   assign mult_sel  = mult_q;
   assign range_sel = range_q;

   // R3: configuration frozen while the loop runs
   a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      on_q |=> ($stable(range_q) && $stable(mult_q)));
   // R4: zero range vetoes loop enable and clock select
   a_r4_zero_range_veto: assert property (@(posedge clk) disable iff (!rst_n)
      (range_q == 4'd0) |-> (!on_q && !cs_q));
   // R8: no request without the enable
   a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ie_q);
endmodule

// File: tb/pllc_ctrl_test.sv
module pllc_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       lock_in = 1'b0;
   logic       pll_en, clk_sel, irq;
   logic [3:0] mult_sel, range_sel;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   pllc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .lock_in(lock_in), .pll_en(pll_en), .clk_sel(clk_sel),
      .mult_sel(mult_sel), .range_sel(range_sel), .irq(irq)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(logic [1:0] a, logic [7:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      idle(2);
      rst_n = 1;
      idle(1);
      // R1 reset state
      rd(2'd0, d); check("R1 ctrl", d, 8'h00);
      rd(2'd1, d); check("R1 bw", d, 8'h00);
      rd(2'd2, d); check("R1 cfg", d, 8'h61);
      check("R1 outputs", {pll_en, clk_sel, irq, range_sel}, {3'b000, 4'd6});
      rd(2'd3, d); check("R2 unused addr", d, 8'h00);

      // R2 sweep of configuration with loop stopped
      for (int v = 0; v < 256; v++) begin
         wr(2'd2, 8'(v));
         rd(2'd2, d); check("R2 cfg readback", d, 8'(v));
         check("R2 cfg outputs", {range_sel, mult_sel}, 8'(v));
      end
      // range is 0xF now; R4 veto with zero range
      wr(2'd2, 8'h03);
      wr(2'd0, 8'h30);
      check("R4 zero range refuses", {6'b0, pll_en, clk_sel}, 8'h00);
      rd(2'd0, d); check("R4 ctrl read", d, 8'h00);
      // start loop with nonzero range, then R3 sweep
      wr(2'd2, 8'h52);
      wr(2'd0, 8'h30);
      check("R4 nonzero range allows", {6'b0, pll_en, clk_sel}, 8'h03);
      for (int v = 0; v < 256; v++) begin
         wr(2'd2, 8'(v));
         rd(2'd2, d); check("R3 frozen cfg", d, 8'h52);
      end
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      check("R4 range zero clears", {6'b0, pll_en, clk_sel}, 8'h00);
      wr(2'd2, 8'h74);

      // R7 manual mode: changes ignored
      lock_in = 1; idle(4);
      rd(2'd0, d); check("R7 flag stays 0", d & 8'h40, 8'h00);
      check("R7 irq low", {7'b0, irq}, 8'h00);
      rd(2'd1, d); check("R10 lock level", d, 8'h40);

      // R5 / R6 automatic mode, enable off, falling change
      wr(2'd1, 8'h80);
      lock_in = 0; idle(2);
      rd(2'd0, d); check("R5 flag not before third edge", d & 8'h40, 8'h00);
      // that read clock edge is the third: flag now set
      rd(2'd0, d); check("R6 flag set without enable", d & 8'h40, 8'h40);
      check("R6 irq off without enable", {7'b0, irq}, 8'h00);
      rd(2'd0, d); check("R9 read cleared flag", d & 8'h40, 8'h00);
      idle(4);
      rd(2'd0, d); check("R5 one change sets once", d & 8'h40, 8'h00);

      // R8 rising change with enable
      wr(2'd0, 8'h80);
      lock_in = 1; idle(3);
      check("R8 irq raised", {7'b0, irq}, 8'h01);
      rd(2'd1, d); check("R10 lock level rise", d, 8'hC0);
      // R11 write to flag bit ignored
      wr(2'd0, 8'hC0 & 8'hBF);
      check("R11 write keeps flag", {7'b0, irq}, 8'h01);
      wr(2'd0, 8'h00);
      check("R8 irq follows enable", {7'b0, irq}, 8'h00);
      wr(2'd0, 8'h80);
      check("R8 irq re-enabled", {7'b0, irq}, 8'h01);

      // R9 read collides with a change arriving at the flag
      lock_in = 0; idle(2);
      rd(2'd0, d); check("R9 collision read sees flag", d & 8'h40, 8'h40);
      check("R9 change wins", {7'b0, irq}, 8'h01);
      rd(2'd0, d); check("R9 flag still set", d & 8'h40, 8'h40);
      rd(2'd0, d); check("R9 then cleared", d & 8'h40, 8'h00);

      // R11 write of 1 to flag bit while clear
      wr(2'd0, 8'hC0);
      rd(2'd0, d); check("R11 flag not writable", d & 8'h40, 8'h00);

      // R7 leaving automatic mode clears a set flag
      lock_in = 1; idle(3);
      check("R7 setup irq", {7'b0, irq}, 8'h01);
      wr(2'd1, 8'h00); idle(1);
      rd(2'd0, d); check("R7 manual clears flag", d & 8'h40, 8'h00);
      check("R7 manual irq low", {7'b0, irq}, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule